// File: doc/BRIEF.md
# Dual-Comparator Trigger Sequencer

This block watches a stream of bus cycles and compares each one against two programmable comparators, A and B. Comparator A holds an address. Comparator B holds an address and a data value. A mode field selects how the two results combine. Some modes look at a single cycle. Others remember an earlier A hit. The range modes treat the two addresses as the bounds of a span.

In trace operation the block produces a one-cycle trigger pulse for a capture unit. In the two event-only-B modes it instead reports every qualifying B hit together with the data of that cycle. In breakpoint operation the trace outputs stay quiet. The block then raises a one-cycle request, either for background debug entry or for a software interrupt, depending on a select bit. All configuration goes through a simple write port. A write to the control word also arms the sequencer or disarms it.

Top module: `dualcmp_trigger`

## Requirements
- R1: After reset every output is low and the sequencer is disarmed (`armed`=0).
- R2: The write port has four words, selected by `cfgAddr`: 0 holds the A address, 1 the B address, 2 the B data (taken from the low DW bits), and 3 the control word. The control word is laid out as mode=[3:0], breakpoint select=[4], software-interrupt select=[5] and arm=[6]. Any write to word 3 sets `armed` to bit 6 and clears the A-seen history. While the sequencer is disarmed, no output pulses.
- R3: In the trace modes (mode 0, 1, 2, 5, 6, 7, 8 with the breakpoint select at 0), a qualifying bus cycle at clock edge k drives `trigPulse` high for exactly the cycle after edge k. The sequencer then disarms and ignores further matches until it is re-armed.
- R4: Mode 0 fires when the address equals A. Mode 1 fires when the address equals A or equals B.
- R5: Mode 2 fires on a B address hit only if an A address hit happened in an earlier armed cycle. A cycle that hits both A and B does not fire by itself.
- R6: Mode 3 (every B hit) and mode 4 (B hits after an earlier A hit) give a one-cycle `capValid` pulse for each qualifying B address hit, with `capData` holding that cycle's data. These modes stay armed and never pulse `trigPulse`.
- R7: Mode 5 fires when the address equals A and the data equals the B data. Mode 6 fires when the address equals A and the data differs from the B data.
- R8: Mode 7 fires when A ≤ address ≤ B, with both bounds included. When A > B the range is empty and mode 7 never fires.
- R9: Mode 8 fires when the address lies outside the inclusive span [A, B].
- R10: With the breakpoint select at 1, the trace outputs stay low. Mode bit 0 = 0 fires on an A or B address hit. Mode bit 0 = 1 fires when the address equals A and the data equals the B data. The action is a one-cycle `swiReq` if the software-interrupt select is 1, otherwise a one-cycle `bdmReq`. After that the sequencer disarms.
- R11: Bus cycles with `busValid` low never fire, never capture and never set the A-seen history.
- R12: Trace mode codes 9 to 15 never produce any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration word select |
| cfgWdata | input | AW | Configuration write data |
| busValid | input | 1 | Bus cycle present this clock |
| busAddr | input | AW | Bus cycle address |
| busData | input | DW | Bus cycle data |
| trigPulse | output | 1 | Trace trigger pulse |
| capValid | output | 1 | Event capture pulse |
| capData | output | DW | Data captured on the event |
| bdmReq | output | 1 | Background debug entry request |
| swiReq | output | 1 | Software interrupt request |
| armed | output | 1 | Sequencer armed |

## Verification
The bench builds the block with AW=10 and DW=8. With these widths the address space is small enough to put range bounds on the lowest and highest addresses. The bench can then check the inclusive edges at 0x000 and 0x3FF directly, and check outside-range hits on both sides of the span. Eight-bit data keeps the full-mode checks able to set the data equal to the B value and then off by one bit.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [3:0] {
    MODE_A_ONLY   = 4'd0,
    MODE_A_OR_B   = 4'd1,
    MODE_A_THEN_B = 4'd2,
    MODE_EV_B     = 4'd3,
    MODE_A_THEN_EV= 4'd4,
    MODE_A_AND_B  = 4'd5,
    MODE_A_NOT_B  = 4'd6,
    MODE_INSIDE   = 4'd7,
    MODE_OUTSIDE  = 4'd8
  } trigMode_e;

  // Comparator results handed from datapath to control
  typedef struct packed {
    logic aAddrHit;
    logic bAddrHit;
    logic bDataHit;
    logic inRange;
  } hits_t;

  // Configuration fields the control needs
  typedef struct packed {
    logic [3:0] mode;
    logic       bkptSel;
    logic       swiSel;
  } ctrlCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capLoad;
  } strobes_t;

  localparam int CFG_A_ADDR = 0;
  localparam int CFG_B_ADDR = 1;
  localparam int CFG_B_DATA = 2;
  localparam int CFG_CTRL   = 3;

endpackage

// File: rtl/dct_datapath.sv
module dct_datapath
  import dct_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [1:0]    cfgAddr,
  input  logic [AW-1:0] cfgWdata,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busData,
  input  strobes_t      strobes,
  output hits_t         hits,
  output ctrlCfg_t      cfg,
  output logic [DW-1:0] capData
);

  logic [AW-1:0] aAddr;
  logic [AW-1:0] bAddr;
  logic [DW-1:0] bData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aAddr <= '0;
      bAddr <= '0;
      bData <= '0;
      cfg   <= '0;
    end else if (cfgWe) begin
      case (cfgAddr)
        2'(CFG_A_ADDR): aAddr <= cfgWdata;
        2'(CFG_B_ADDR): bAddr <= cfgWdata;
        2'(CFG_B_DATA): bData <= cfgWdata[DW-1:0];
        default: begin
          cfg.mode    <= cfgWdata[3:0];
          cfg.bkptSel <= cfgWdata[4];
          cfg.swiSel  <= cfgWdata[5];
        end
      endcase
    end
  end

  logic aboveLow;
  logic belowHigh;

  always_comb begin
    aboveLow      = busAddr >= aAddr;
    belowHigh     = busAddr <= bAddr;
    hits.aAddrHit = busAddr == aAddr;
    hits.bAddrHit = busAddr == bAddr;
    hits.bDataHit = busData == bData;
    hits.inRange  = aboveLow && belowHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capData <= '0;
    else if (strobes.capLoad) capData <= busData;
  end

  // R8: an inverted span holds no address
  assert_empty_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (aAddr > bAddr) |-> !hits.inRange);

  // R6: captured data follows the bus data of the capture cycle
  assert_cap_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capLoad |=> (capData == $past(busData)));

endmodule

// File: rtl/dct_control.sv
module dct_control
  import dct_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     ctrlWr,
  input  logic     armBit,
  input  logic     busValid,
  input  hits_t    hits,
  input  ctrlCfg_t cfg,
  output strobes_t strobes,
  output logic     trigPulse,
  output logic     capValid,
  output logic     bdmReq,
  output logic     swiReq,
  output logic     armed
);

  logic seenA;
  logic live;
  logic traceCond;
  logic evCond;
  logic bkptCond;
  logic seqMode;
  logic traceFire;
  logic evFire;
  logic bkptFire;

  always_comb begin
    traceCond = 1'b0;
    evCond    = 1'b0;
    seqMode   = 1'b0;
    case (cfg.mode)
      MODE_A_ONLY:    traceCond = hits.aAddrHit;
      MODE_A_OR_B:    traceCond = hits.aAddrHit || hits.bAddrHit;
      MODE_A_THEN_B: begin
        seqMode   = 1'b1;
        traceCond = seenA && hits.bAddrHit;
      end
      MODE_EV_B:      evCond = hits.bAddrHit;
      MODE_A_THEN_EV: begin
        seqMode = 1'b1;
        evCond  = seenA && hits.bAddrHit;
      end
      MODE_A_AND_B:   traceCond = hits.aAddrHit && hits.bDataHit;
      MODE_A_NOT_B:   traceCond = hits.aAddrHit && !hits.bDataHit;
      MODE_INSIDE:    traceCond = hits.inRange;
      MODE_OUTSIDE:   traceCond = !hits.inRange;
      default: ;
    endcase
    bkptCond = cfg.mode[0] ? (hits.aAddrHit && hits.bDataHit)
                           : (hits.aAddrHit || hits.bAddrHit);
    live      = armed && busValid;
    traceFire = live && !cfg.bkptSel && traceCond;
    evFire    = live && !cfg.bkptSel && evCond;
    bkptFire  = live && cfg.bkptSel && bkptCond;
    strobes.capLoad = evFire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      seenA <= 1'b0;
    end else if (ctrlWr) begin
      armed <= armBit;
      seenA <= 1'b0;
    end else begin
      if (traceFire || bkptFire) armed <= 1'b0;
      if (live && seqMode && !cfg.bkptSel && hits.aAddrHit) seenA <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPulse <= 1'b0;
      capValid  <= 1'b0;
      bdmReq    <= 1'b0;
      swiReq    <= 1'b0;
    end else begin
      trigPulse <= traceFire;
      capValid  <= evFire;
      bdmReq    <= bkptFire && !cfg.swiSel;
      swiReq    <= bkptFire && cfg.swiSel;
    end
  end

  // R3, R10: a firing cycle leaves the sequencer disarmed unless re-armed
  assert_disarm_after_fire_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((trigPulse || bdmReq || swiReq) && !$past(ctrlWr)) |-> !armed);

  // R2: outputs pulse only from an armed sequencer
  assert_needs_armed_R2: assert property (@(posedge clk) disable iff (!rstN)
    (trigPulse || capValid || bdmReq || swiReq) |-> $past(armed));

  // R10: breakpoint and trace outputs never overlap
  assert_exclusive_out_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({trigPulse, capValid, bdmReq, swiReq}));

  // R11: idle bus cycles produce nothing
  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !(trigPulse || capValid || bdmReq || swiReq));

  // R5: an ordered trigger requires history from an earlier cycle
  assert_ordered_R5: assert property (@(posedge clk) disable iff (!rstN)
    (trigPulse && $past(cfg.mode) == MODE_A_THEN_B && $past(cfg.mode) == cfg.mode)
      |-> $past(seenA));

endmodule

// File: rtl/dualcmp_trigger.sv
module dualcmp_trigger
  import dct_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [1:0]    cfgAddr,
  input  logic [AW-1:0] cfgWdata,
  input  logic          busValid,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busData,
  output logic          trigPulse,
  output logic          capValid,
  output logic [DW-1:0] capData,
  output logic          bdmReq,
  output logic          swiReq,
  output logic          armed
);

  hits_t    hits;
  ctrlCfg_t cfg;
  strobes_t strobes;
  logic     ctrlWr;

  assign ctrlWr = cfgWe && (cfgAddr == 2'(CFG_CTRL));

  dct_datapath #(.AW(AW), .DW(DW)) datapath_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .busAddr(busAddr), .busData(busData),
    .strobes(strobes), .hits(hits), .cfg(cfg), .capData(capData)
  );

  dct_control control_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .armBit(cfgWdata[6]),
    .busValid(busValid), .hits(hits), .cfg(cfg), .strobes(strobes),
    .trigPulse(trigPulse), .capValid(capValid), .bdmReq(bdmReq),
    .swiReq(swiReq), .armed(armed)
  );

endmodule

// File: tb/dualcmp_trigger_tb.sv
module dualcmp_trigger_tb_top;
  localparam int AW = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [1:0]    cfgAddr = '0;
  logic [AW-1:0] cfgWdata = '0;
  logic          busValid = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busData = '0;
  logic          trigPulse, capValid, bdmReq, swiReq, armed;
  logic [DW-1:0] capData;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dualcmp_trigger #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .busValid(busValid), .busAddr(busAddr),
    .busData(busData), .trigPulse(trigPulse), .capValid(capValid),
    .capData(capData), .bdmReq(bdmReq), .swiReq(swiReq), .armed(armed)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 2'(a); cfgWdata = AW'(d);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // ctrl: mode [3:0], bkpt [4], swi [5], arm [6]
  task automatic arm(input int mode, input bit bk, input bit swi);
    wr(3, mode | (int'(bk) << 4) | (int'(swi) << 5) | (1 << 6));
  endtask

  // One bus cycle; returns {swi, bdm, cap, trig} seen the cycle after
  task automatic cyc(input int a, input int d, input bit v, output logic [3:0] o);
    @(negedge clk);
    busValid = v; busAddr = AW'(a); busData = DW'(d);
    @(negedge clk);
    o = {swiReq, bdmReq, capValid, trigPulse};
    busValid = 1'b0;
  endtask

  task automatic setAB(input int a, input int b, input int bd);
    wr(0, a); wr(1, b); wr(2, bd);
  endtask

  task automatic t_reset();
    check("R1 outputs", int'({trigPulse, capValid, bdmReq, swiReq}), 0);
    check("R1 armed", int'(armed), 0);
  endtask

  task automatic t_aOnly();
    logic [3:0] o;
    setAB(10'h123, 10'h200, 8'h55);
    wr(3, 0);                   // disarmed, mode 0
    cyc(10'h123, 0, 1, o); check("R2 disarmed silent", int'(o), 0);
    arm(0, 0, 0);
    check("R2 armed", int'(armed), 1);
    cyc(10'h124, 0, 1, o); check("R4 A-only miss", int'(o), 0);
    cyc(10'h123, 0, 0, o); check("R11 invalid cycle", int'(o), 0);
    cyc(10'h123, 0, 1, o); check("R4 A-only hit", int'(o), 1);
    check("R3 disarm", int'(armed), 0);
    @(negedge clk); check("R3 single cycle", int'(trigPulse), 0);
    cyc(10'h123, 0, 1, o); check("R3 idle until rearm", int'(o), 0);
    arm(1, 0, 0);
    cyc(10'h200, 0, 1, o); check("R4 A-or-B via B", int'(o), 1);
  endtask

  task automatic t_aThenB();
    logic [3:0] o;
    setAB(10'h040, 10'h080, 0);
    arm(2, 0, 0);
    cyc(10'h080, 0, 1, o); check("R5 B before A", int'(o), 0);
    cyc(10'h040, 0, 0, o); check("R11 invalid A", int'(o), 0);
    cyc(10'h080, 0, 1, o); check("R11 no history from invalid A", int'(o), 0);
    cyc(10'h040, 0, 1, o); check("R5 A alone", int'(o), 0);
    cyc(10'h080, 0, 1, o); check("R5 B after A", int'(o), 1);
    setAB(10'h050, 10'h050, 0);
    arm(2, 0, 0);
    cyc(10'h050, 0, 1, o); check("R5 same-cycle A and B", int'(o), 0);
    cyc(10'h050, 0, 1, o); check("R5 second joint hit", int'(o), 1);
  endtask

  task automatic t_event();
    logic [3:0] o;
    setAB(10'h010, 10'h020, 0);
    arm(3, 0, 0);
    cyc(10'h020, 8'hA5, 1, o); check("R6 event 1", int'(o), 4'b0010);
    check("R6 data 1", int'(capData), 8'hA5);
    cyc(10'h020, 8'h3C, 1, o); check("R6 event 2", int'(o), 4'b0010);
    check("R6 data 2", int'(capData), 8'h3C);
    check("R6 stays armed", int'(armed), 1);
    cyc(10'h010, 8'h77, 1, o); check("R6 A ignored", int'(o), 0);
    arm(4, 0, 0);
    cyc(10'h020, 8'h11, 1, o); check("R6 B before A", int'(o), 0);
    check("R6 data held", int'(capData), 8'h3C);
    cyc(10'h010, 8'h22, 1, o);
    cyc(10'h020, 8'h33, 1, o); check("R6 B after A", int'(o), 4'b0010);
    check("R6 data after A", int'(capData), 8'h33);
  endtask

  task automatic t_full();
    logic [3:0] o;
    setAB(10'h0F0, 10'h300, 8'h5A);
    arm(5, 0, 0);
    cyc(10'h0F0, 8'h5B, 1, o); check("R7 and: data off", int'(o), 0);
    cyc(10'h300, 8'h5A, 1, o); check("R7 and: addr off", int'(o), 0);
    cyc(10'h0F0, 8'h5A, 1, o); check("R7 and: hit", int'(o), 1);
    arm(6, 0, 0);
    cyc(10'h0F0, 8'h5A, 1, o); check("R7 not: data equal", int'(o), 0);
    cyc(10'h0F0, 8'h5B, 1, o); check("R7 not: hit", int'(o), 1);
  endtask

  task automatic t_range();
    logic [3:0] o;
    setAB(10'h100, 10'h200, 0);
    arm(7, 0, 0);
    cyc(10'h0FF, 0, 1, o); check("R8 below", int'(o), 0);
    cyc(10'h100, 0, 1, o); check("R8 low bound", int'(o), 1);
    arm(7, 0, 0);
    cyc(10'h201, 0, 1, o); check("R8 above", int'(o), 0);
    cyc(10'h200, 0, 1, o); check("R8 high bound", int'(o), 1);
    setAB(10'h000, 10'h3FF, 0);
    arm(7, 0, 0);
    cyc(10'h3FF, 0, 1, o); check("R8 full span top", int'(o), 1);
    arm(8, 0, 0);
    cyc(10'h000, 0, 1, o); check("R9 full span no outside", int'(o), 0);
    setAB(10'h200, 10'h100, 0);
    arm(7, 0, 0);
    cyc(10'h150, 0, 1, o); check("R8 empty mid", int'(o), 0);
    cyc(10'h200, 0, 1, o); check("R8 empty at A", int'(o), 0);
    setAB(10'h100, 10'h200, 0);
    arm(8, 0, 0);
    cyc(10'h150, 0, 1, o); check("R9 inside", int'(o), 0);
    cyc(10'h200, 0, 1, o); check("R9 bound", int'(o), 0);
    cyc(10'h3FF, 0, 1, o); check("R9 above", int'(o), 1);
    arm(8, 0, 0);
    cyc(10'h000, 0, 1, o); check("R9 below", int'(o), 1);
  endtask

  task automatic t_bkpt();
    logic [3:0] o;
    setAB(10'h0AA, 10'h0BB, 8'hC3);
    arm(0, 1, 1);
    cyc(10'h0CC, 0, 1, o); check("R10 dual miss", int'(o), 0);
    cyc(10'h0BB, 0, 1, o); check("R10 dual swi", int'(o), 4'b1000);
    check("R10 disarm", int'(armed), 0);
    arm(0, 1, 0);
    cyc(10'h0AA, 0, 1, o); check("R10 dual bdm", int'(o), 4'b0100);
    arm(1, 1, 0);
    cyc(10'h0BB, 8'hC3, 1, o); check("R10 full addr off", int'(o), 0);
    cyc(10'h0AA, 8'hC2, 1, o); check("R10 full data off", int'(o), 0);
    cyc(10'h0AA, 8'hC3, 1, o); check("R10 full bdm", int'(o), 4'b0100);
  endtask

  task automatic t_badMode();
    logic [3:0] o;
    setAB(10'h000, 10'h000, 8'h00);
    for (int m = 9; m < 16; m++) begin
      arm(m, 0, 0);
      cyc(10'h000, 8'h00, 1, o); check("R12 unused mode", int'(o), 0);
    end
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_aOnly();
    t_aThenB();
    t_event();
    t_full();
    t_range();
    t_bkpt();
    t_badMode();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule